// File: doc/BRIEF.md
# Multi-Lane Banked Scratchpad with Conflict Replay

This block is a scratchpad memory shared by 32 lanes. In one request every lane gives a word address, a read or write flag, write data and an active bit. Word addresses are interleaved across 32 single-port banks. A full lane-to-bank crossbar lets any lane reach any bank, so both contiguous and scattered patterns are served.

Lanes that target different words in the same bank cannot be served at once. The block splits such a request into conflict-free passes on successive cycles. While the passes run it drops its ready output, so the issuing side holds the next request. All read data comes back together, with a single done pulse, after the last pass.

Each bank holds `DEPTH` words of `DW` bits. The full-size array is 1024 words per bank, which gives 4 KB per bank and 128 KB in total. The default parameter is smaller so that elaboration stays cheap.

Top module: `banked_scratchpad`

## Requirements
- R1: A word address maps to bank = address mod 32 (the low 5 bits) and row = address / 32. A request in which all 32 lanes touch 32 contiguous words completes in exactly one pass.
- R2: After reset, `req_ready` is 1 and `rsp_valid` is 0. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1.
- R3: The number of passes equals the largest count of distinct words that active lanes request from any one bank, and is never less than one. `req_ready` is 0 during the passes. `rsp_valid` is high for exactly the one cycle after the clock edge of the final pass, and `req_ready` is 1 again in that same cycle.
- R4: Lanes that request the identical word are served in the same pass as a broadcast and do not add a pass.
- R5: When several lanes write the same word in one request, the data of the highest-numbered of those lanes is what remains stored.
- R6: A lane that reads a word which another lane writes in the same request returns the value the word held before the request.
- R7: A lane whose active bit is 0 neither reads nor writes memory and does not count toward the pass number. Its `lane_rdata` slice is zero.
- R8: Each read lane returns the stored word in its `lane_rdata` slice (slice l is bits [32*l+31:32*l]). A write lane returns zero. The data stays unchanged until the next request is accepted.
- R9: Any scattered mix of reads and writes over all banks gives the same memory contents and read data as performing the writes in ascending lane order after all reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | The block can accept a request |
| lane_act | input | 32 | Per-lane active bits |
| lane_we | input | 32 | Per-lane write flag (1 = write) |
| lane_addr | input | 32*11 | Per-lane word address, lane l at [11*l +: 11] |
| lane_wdata | input | 32*32 | Per-lane write data |
| rsp_valid | output | 1 | One-cycle done pulse after the final pass |
| lane_rdata | output | 32*32 | Per-lane read data |

## Verification
The pass counter is not visible at the ports, but a fault in conflict grouping shows up at once in the response time. A missed conflict ends the request a cycle or more early, and a falsely split broadcast ends it late. The testbench therefore measures the accept-to-done delay of every request and compares it against a count it computes itself. A wrong pending mask or crossbar route produces read data for the wrong lane, and this appears in the same response. A misplaced write only appears at a later read of that word. For this reason the bench keeps its own copy of the memory and reads words back after the collision, inactive-lane and scatter scenarios.

// File: rtl/banked_scratchpad.sv
module banked_scratchpad #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int DEPTH = 64,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LANES-1:0]      lane_act,
  input  logic [LANES-1:0]      lane_we,
  input  logic [LANES*($clog2(BANKS)+$clog2(DEPTH))-1:0] lane_addr,
  input  logic [LANES*DW-1:0]   lane_wdata,
  output logic                  rsp_valid,
  output logic [LANES*DW-1:0]   lane_rdata
);
  localparam int BW = $clog2(BANKS);
  localparam int RW = $clog2(DEPTH);
  localparam int AW = BW + RW;

  logic [DW-1:0] mem [BANKS][DEPTH];

  logic             busy, rsp_q;
  logic [LANES-1:0] act_q, we_q, pend, served;
  logic [AW-1:0]    addr_q [LANES];
  logic [DW-1:0]    wdat_q [LANES];
  logic [DW-1:0]    rdat_q [LANES];

  logic [RW-1:0]    lead_row [BANKS];
  logic [BANKS-1:0] wr_en;
  logic [RW-1:0]    wr_row [BANKS];
  logic [DW-1:0]    wr_val [BANKS];

  assign req_ready = !busy;
  assign rsp_valid = rsp_q;

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign lane_rdata[g*DW +: DW] = rdat_q[g];
  end

  // lowest pending lane picks the word each bank serves this pass
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      lead_row[b] = '0;
      for (int l = LANES-1; l >= 0; l--)
        if (pend[l] && addr_q[l][BW-1:0] == BW'(b))
          lead_row[b] = addr_q[l][AW-1:BW];
    end
    for (int l = 0; l < LANES; l++)
      served[l] = pend[l] && (addr_q[l][AW-1:BW] == lead_row[addr_q[l][BW-1:0]]);
  end

  // highest served writer of a word wins
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      wr_en[b]  = 1'b0;
      wr_row[b] = lead_row[b];
      wr_val[b] = '0;
      for (int l = 0; l < LANES; l++)
        if (served[l] && we_q[l] && addr_q[l][BW-1:0] == BW'(b)) begin
          wr_en[b]  = 1'b1;
          wr_val[b] = wdat_q[l];
        end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BANKS; b++)
      if (busy && wr_en[b]) mem[b][wr_row[b]] <= wr_val[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      rsp_q <= 1'b0;
      act_q <= '0;
      we_q  <= '0;
      pend  <= '0;
      for (int l = 0; l < LANES; l++) begin
        addr_q[l] <= '0;
        wdat_q[l] <= '0;
        rdat_q[l] <= '0;
      end
    end else if (!busy) begin
      rsp_q <= 1'b0;
      if (req_valid) begin
        busy  <= 1'b1;
        act_q <= lane_act;
        we_q  <= lane_we;
        pend  <= lane_act;
        for (int l = 0; l < LANES; l++) begin
          addr_q[l] <= lane_addr[l*AW +: AW];
          wdat_q[l] <= lane_wdata[l*DW +: DW];
          rdat_q[l] <= '0;
        end
      end
    end else begin
      pend <= pend & ~served;
      for (int l = 0; l < LANES; l++)
        if (served[l] && !we_q[l])
          rdat_q[l] <= mem[addr_q[l][BW-1:0]][addr_q[l][AW-1:BW]];
      if ((pend & ~served) == '0) begin
        busy  <= 1'b0;
        rsp_q <= 1'b1;
      end
    end
  end

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_hold_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_done_follows_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(busy));
  assert_progress_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (served != '0 || pend == '0));
  assert_only_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (served & ~act_q) == '0);
  assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid && !rsp_valid) |=> $stable(lane_rdata));
endmodule

// File: tb/banked_scratchpad_tb.sv
module banked_scratchpad_tb;
  localparam int L = 32, AW = 11, DW = 32, WORDS = 2048;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic req_ready, rsp_valid;
  logic [L-1:0] lane_act = '0, lane_we = '0;
  logic [L*AW-1:0] lane_addr = '0;
  logic [L*DW-1:0] lane_wdata = '0, lane_rdata;

  banked_scratchpad u_dut (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .lane_act(lane_act), .lane_we(lane_we), .lane_addr(lane_addr), .lane_wdata(lane_wdata),
    .rsp_valid(rsp_valid), .lane_rdata(lane_rdata));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  logic [DW-1:0] shadow [WORDS];
  logic [L-1:0] t_act, t_we;
  logic [AW-1:0] t_addr [L];
  logic [DW-1:0] t_data [L];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input string tag, input int exp_passes_override);
    int exp_passes, n;
    logic [DW-1:0] exp_rd [L];
    exp_passes = 1;
    for (int b = 0; b < 32; b++) begin
      int cnt = 0;
      for (int l = 0; l < L; l++) begin
        bit first = 1'b1;
        if (!t_act[l] || t_addr[l][4:0] != 5'(b)) continue;
        for (int k = 0; k < l; k++) if (t_act[k] && t_addr[k] == t_addr[l]) first = 1'b0;
        if (first) cnt++;
      end
      if (cnt > exp_passes) exp_passes = cnt;
    end
    if (exp_passes_override > 0)
      chk(exp_passes == exp_passes_override, {tag, " bench pass model"}, exp_passes, exp_passes_override);
    for (int l = 0; l < L; l++)
      exp_rd[l] = (t_act[l] && !t_we[l]) ? shadow[t_addr[l]] : '0;
    for (int l = 0; l < L; l++)
      if (t_act[l] && t_we[l]) shadow[t_addr[l]] = t_data[l];
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " ready before request R2"}, req_ready, 1);
    lane_act = t_act; lane_we = t_we;
    for (int l = 0; l < L; l++) begin
      lane_addr[l*AW +: AW] = t_addr[l];
      lane_wdata[l*DW +: DW] = t_data[l];
    end
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lane_act = '0; lane_we = '0;
    chk(req_ready == 1'b0 && rsp_valid == 1'b0, {tag, " busy after accept R3"}, {req_ready, rsp_valid}, 0);
    n = 0;
    while (n < 64) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (rsp_valid) break;
    end
    chk(n == exp_passes, {tag, " pass count R3"}, n, exp_passes);
    chk(req_ready == 1'b1, {tag, " ready with done R3"}, req_ready, 1);
    for (int l = 0; l < L; l++)
      chk(lane_rdata[l*DW +: DW] === exp_rd[l], {tag, " lane data R8"}, lane_rdata[l*DW +: DW], exp_rd[l]);
    @(negedge clk);
    chk(rsp_valid == 1'b0, {tag, " done is one cycle R3"}, rsp_valid, 0);
  endtask

  task automatic set_all(input bit act, input bit we);
    for (int l = 0; l < L; l++) begin
      t_act[l] = act; t_we[l] = we; t_addr[l] = '0; t_data[l] = '0;
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "reset ready R2", req_ready, 1);
    chk(rsp_valid == 1'b0, "reset done low R2", rsp_valid, 0);
  endtask

  task automatic t_fill;
    for (int r = 0; r < WORDS/L; r++) begin
      set_all(1, 1);
      for (int l = 0; l < L; l++) begin
        t_addr[l] = AW'(r*L + l);
        t_data[l] = 32'hC0DE_0000 | (r*L + l);
      end
      do_req("fill contiguous write R1", 1);
    end
  endtask

  task automatic t_contig_read;
    set_all(1, 0);
    for (int l = 0; l < L; l++) t_addr[l] = AW'(96 + ((l + 7) % 32));
    do_req("contiguous rotated read R1", 1);
  endtask

  task automatic t_same_bank;
    set_all(1, 0);
    for (int l = 0; l < L; l++) t_addr[l] = AW'(l*32 + 3);
    do_req("one bank 32 words R3 R9", 32);
    set_all(1, 0);
    for (int l = 0; l < L; l++) t_addr[l] = AW'((l % 16) + 32*(l / 16) + 64);
    do_req("two-way conflict R3", 2);
  endtask

  task automatic t_broadcast;
    set_all(1, 0);
    for (int l = 0; l < L; l++) t_addr[l] = 11'd5;
    do_req("full broadcast R4", 1);
    set_all(1, 0);
    for (int l = 0; l < L; l++) t_addr[l] = (l % 2 == 0) ? 11'd5 : 11'd37;
    do_req("two broadcast groups R4", 2);
  endtask

  task automatic t_collide;
    set_all(1, 1);
    for (int l = 0; l < L; l++) begin t_addr[l] = 11'd9; t_data[l] = 32'hBEEF_0000 | l; end
    do_req("write collision R5", 1);
    set_all(0, 0);
    t_act[0] = 1'b1; t_addr[0] = 11'd9;
    do_req("collision readback R5", 1);
    chk(lane_rdata[31:0] == 32'hBEEF_001F, "highest lane wins R5", lane_rdata[31:0], 32'hBEEF_001F);
  endtask

  task automatic t_read_old;
    set_all(0, 0);
    t_act[0] = 1'b1; t_we[0] = 1'b1; t_addr[0] = 11'd10; t_data[0] = 32'h1234_5678;
    t_act[1] = 1'b1; t_addr[1] = 11'd10;
    t_act[2] = 1'b1; t_addr[2] = 11'd42;
    do_req("read sees old value R6", 2);
    chk(lane_rdata[63:32] == (32'hC0DE_0000 | 10), "old word returned R6", lane_rdata[63:32], 32'hC0DE_000A);
  endtask

  task automatic t_inactive;
    set_all(1, 0);
    for (int l = 0; l < L; l++) begin
      t_act[l] = (l < 16);
      t_we[l]  = (l >= 16);
      t_addr[l] = (l < 16) ? AW'(200 + l) : AW'(l*32 + 1);
      t_data[l] = 32'hDEAD_DEAD;
    end
    do_req("inactive lanes ignored R7", 1);
    set_all(1, 0);
    for (int l = 0; l < L; l++) t_addr[l] = AW'(l*32 + 1);
    do_req("inactive writes left memory R7", 32);
    set_all(0, 1);
    do_req("no active lanes R7 R3", 1);
  endtask

  task automatic t_hold;
    logic [31:0] snap;
    set_all(1, 0);
    for (int l = 0; l < L; l++) t_addr[l] = AW'(500 + l);
    do_req("hold setup R8", 1);
    snap = lane_rdata[5*DW +: DW];
    repeat (5) @(negedge clk);
    chk(lane_rdata[5*DW +: DW] == snap, "read data held R8", lane_rdata[5*DW +: DW], snap);
  endtask

  task automatic t_scatter;
    for (int r = 0; r < 40; r++) begin
      for (int l = 0; l < L; l++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        t_act[l]  = lfsr[3:0] != 4'h0;
        t_we[l]   = lfsr[5];
        t_addr[l] = (r % 3 == 0) ? AW'({lfsr[9:8], lfsr[2:0]}) : AW'(lfsr[20:10]);
        t_data[l] = lfsr ^ 32'h5A5A_5A5A;
      end
      do_req("random scatter R9", 0);
    end
    for (int r = 0; r < WORDS/L; r++) begin
      set_all(1, 0);
      for (int l = 0; l < L; l++) t_addr[l] = AW'(r*L + l);
      do_req("final memory sweep R9", 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fill();
    t_contig_read();
    t_same_bank();
    t_broadcast();
    t_collide();
    t_read_old();
    t_inactive();
    t_hold();
    t_scatter();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule